// File: doc/BRIEF.md
# Mode-Gated System Clock Prescaler

This block turns a fast main clock into a periodic system-clock enable, and turns a slower sub-oscillator tick into a subsystem-clock enable. Both enables last one cycle and are meant to qualify logic that runs on the main clock. The system ratio is 1/4, 1/8, 1/16 or 1/32. Software writes it into a staging register. The new ratio only replaces the running one when the part comes back to active operation from watch or subactive mode. At that moment the system enable is already gated off, so the divider never sees a ratio change while it is running.

A strap input sets the system ratio after reset and whenever stop mode is left. The subsystem ratio is 1/4 or 1/8 and takes effect as soon as it is written. It may only be changed in active mode. A write made in any other mode is dropped and raises a sticky error flag. The power mode comes from an external sequencer and is presented on a 2-bit input.

Top module: `clkpre_top`

## Requirements
- R1: After reset, or on any change of `pwr_mode` away from stop, the committed and staged system ratio codes are both loaded from the strap. `strap_fast`=1 gives code 00 (1/4) and 0 gives code 11 (1/32). The outstanding bit (bit 0 at address 0x29) reads 0.
- R2: In active mode, system code 00/01/10/11 makes `sys_ce` pulse for one cycle every 4/8/16/32 clocks.
- R3: A write to address 0x2A loads bits [1:0] into the staged code only. The running `sys_ce` period does not change. Reading 0x2A returns the staged code in bits [1:0], and bit 0 at 0x29 reads 1 until the next commit.
- R4: Mode encoding is 00 active, 01 subactive, 10 watch, 11 stop, and it is registered once. `sys_ce` stays low whenever the registered mode is not active. The staged code is committed on the clock where the registered mode is watch or subactive and `pwr_mode` is active.
- R5: A commit restarts the system divider. The first `sys_ce` appears N clocks after the committing edge, where N is the new ratio.
- R6: Bits [3:2] written to 0x2A are stored at once, without staging, and read back in bits [3:2] on the next cycle.
- R7: Bit 2 at 0x29 selects a sub ratio of 1/4 (0) or 1/8 (1) of `sub_tick` pulses. It applies from the write edge, with the sub counter restarted. `sub_ce` runs in active and subactive mode and stays low in watch and stop.
- R8: A write to 0x29 while the registered mode is not active leaves bit 2 and the `sub_ce` period unchanged and sets the error flag, which reads in bit 3 at 0x29. Writing 1 to bit 3 in active mode clears the flag.
- R9: Leaving stop mode discards any staged code that was not committed, in favour of the strap code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_fast | input | 1 | Reset ratio strap: 1 selects 1/4, 0 selects 1/32 |
| pwr_mode | input | 2 | Power mode from the sequencer |
| sub_tick | input | 1 | One pulse per sub-oscillator period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 4 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 4 | Read data, combinational |
| sys_ce | output | 1 | System clock enable pulse |
| sub_ce | output | 1 | Subsystem clock enable pulse |

## Verification
If the committed code is corrupted, the `sys_ce` spacing is wrong within one period, so at most 32 clocks later. If a commit is missed or comes early, the first pulse after the resume edge lands on the wrong cycle. A sub-ratio latch that accepts a write outside active mode shows up within one sub period through a changed `sub_ce` spacing, and at once in the readback of 0x29. A broken strap reload after stop shows up in the readback and in the very next period.

// File: rtl/clkpre_pkg.sv
`timescale 1ns/1ps
package clkpre_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE = 2'b00,
    PM_SUBACT = 2'b01,
    PM_WATCH  = 2'b10,
    PM_STOP   = 2'b11
  } pm_e;

  localparam int unsigned DATA_W     = 4;
  localparam int unsigned RATIO_W    = 2;
  localparam int unsigned BASE_SHIFT = 2;
  localparam int unsigned SYS_CNT_W  = BASE_SHIFT + (1 << RATIO_W) - 1;
  localparam int unsigned SUB_CNT_W  = BASE_SHIFT + 1;

  localparam logic [RATIO_W-1:0] CODE_FAST = '0;
  localparam logic [RATIO_W-1:0] CODE_SLOW = '1;
endpackage

// File: rtl/clkpre_rst_sync.sv
`timescale 1ns/1ps
module clkpre_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/clkpre_mode.sv
`timescale 1ns/1ps
module clkpre_mode
  import clkpre_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwr_mode,
  output logic [1:0] mode_q,
  output logic       commit,
  output logic       stop_exit,
  output logic       sys_run,
  output logic       sub_run
);
  pm_e cur_q;
  pm_e cur_d;
  pm_e req;

  assign req   = pm_e'(pwr_mode);
  assign cur_d = req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= PM_STOP;
    else        cur_q <= cur_d;
  end

  assign mode_q    = cur_q;
  assign stop_exit = (cur_q == PM_STOP) && (req != PM_STOP);
  assign commit    = ((cur_q == PM_WATCH) || (cur_q == PM_SUBACT)) && (req == PM_ACTIVE);
  assign sys_run   = (cur_q == PM_ACTIVE);
  assign sub_run   = (cur_q == PM_ACTIVE) || (cur_q == PM_SUBACT);
endmodule

// File: rtl/clkpre_div.sv
`timescale 1ns/1ps
module clkpre_div #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             clr,
  input  logic [CNT_W-1:0] term,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_term;

  assign at_term = (cnt_q == term);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (en)  cnt_d = at_term ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = en && !clr && at_term;
endmodule

// File: rtl/clkpre_regs.sv
`timescale 1ns/1ps
module clkpre_regs
  import clkpre_pkg::*;
#(
  parameter int unsigned        ADDR_W   = 6,
  parameter logic [ADDR_W-1:0]  SUB_ADDR = 6'h29,
  parameter logic [ADDR_W-1:0]  SYS_ADDR = 6'h2A
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  input  logic               strap_fast,
  input  logic [1:0]         mode_q,
  input  logic               commit,
  input  logic               stop_exit,
  output logic [RATIO_W-1:0] sys_code,
  output logic               sub_sel,
  output logic               sub_change,
  output logic               err_flag
);
  logic [RATIO_W-1:0] stage_q, stage_d;
  logic [RATIO_W-1:0] live_q,  live_d;
  logic [1:0]         aux_q,   aux_d;
  logic               owe_q,   owe_d;
  logic               ssel_q,  ssel_d;
  logic               err_q,   err_d;

  logic               hit_sys;
  logic               hit_sub;
  logic               in_active;
  logic [RATIO_W-1:0] strap_code;

  assign hit_sys    = wr_en && (wr_addr == SYS_ADDR);
  assign hit_sub    = wr_en && (wr_addr == SUB_ADDR);
  assign in_active  = (pm_e'(mode_q) == PM_ACTIVE);
  assign strap_code = strap_fast ? CODE_FAST : CODE_SLOW;

  always_comb begin
    stage_d = stage_q;
    live_d  = live_q;
    aux_d   = aux_q;
    owe_d   = owe_q;
    ssel_d  = ssel_q;
    err_d   = err_q;

    if (stop_exit) begin
      stage_d = strap_code;
      live_d  = strap_code;
      owe_d   = 1'b0;
    end else if (commit) begin
      live_d  = stage_q;
      owe_d   = 1'b0;
    end

    if (hit_sys) begin
      stage_d = wr_data[RATIO_W-1:0];
      aux_d   = wr_data[3:2];
      owe_d   = 1'b1;
    end

    if (hit_sub) begin
      if (in_active) begin
        ssel_d = wr_data[2];
        if (wr_data[3]) err_d = 1'b0;
      end else begin
        err_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= CODE_SLOW;
      live_q  <= CODE_SLOW;
      aux_q   <= '0;
      owe_q   <= 1'b0;
      ssel_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      stage_q <= stage_d;
      live_q  <= live_d;
      aux_q   <= aux_d;
      owe_q   <= owe_d;
      ssel_q  <= ssel_d;
      err_q   <= err_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == SUB_ADDR)      rd_data = {err_q, ssel_q, 1'b0, owe_q};
    else if (rd_addr == SYS_ADDR) rd_data = {aux_q, stage_q};
  end

  assign sys_code   = live_q;
  assign sub_sel    = ssel_q;
  assign sub_change = hit_sub && in_active && (wr_data[2] != ssel_q);
  assign err_flag   = err_q;
endmodule

// File: rtl/clkpre_top.sv
`timescale 1ns/1ps
module clkpre_top
  import clkpre_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] SUB_ADDR = 6'h29,
  parameter logic [ADDR_W-1:0] SYS_ADDR = 6'h2A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_fast,
  input  logic [1:0]        pwr_mode,
  input  logic              sub_tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [3:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [3:0]        rd_data,
  output logic              sys_ce,
  output logic              sub_ce
);
  logic                 rst_n_s;
  logic [1:0]           mode_q;
  logic                 commit;
  logic                 stop_exit;
  logic                 sys_run;
  logic                 sub_run;
  logic [RATIO_W-1:0]   sys_code;
  logic                 sub_sel;
  logic                 sub_change;
  logic                 err_flag;
  logic [SYS_CNT_W-1:0] sys_term;
  logic [SUB_CNT_W-1:0] sub_term;

  clkpre_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s)
  );

  clkpre_mode u_mode (
    .clk(clk), .rst_n(rst_n_s), .pwr_mode(pwr_mode),
    .mode_q(mode_q), .commit(commit), .stop_exit(stop_exit),
    .sys_run(sys_run), .sub_run(sub_run)
  );

  clkpre_regs #(.ADDR_W(ADDR_W), .SUB_ADDR(SUB_ADDR), .SYS_ADDR(SYS_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n_s),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .strap_fast(strap_fast), .mode_q(mode_q),
    .commit(commit), .stop_exit(stop_exit),
    .sys_code(sys_code), .sub_sel(sub_sel),
    .sub_change(sub_change), .err_flag(err_flag)
  );

  assign sys_term = SYS_CNT_W'((32'd1 << (BASE_SHIFT + 32'(sys_code))) - 32'd1);
  assign sub_term = SUB_CNT_W'((32'd1 << (BASE_SHIFT + 32'(sub_sel))) - 32'd1);

  clkpre_div #(.CNT_W(SYS_CNT_W)) u_sys_div (
    .clk(clk), .rst_n(rst_n_s), .en(sys_run),
    .clr(commit || stop_exit), .term(sys_term), .tick(sys_ce)
  );

  clkpre_div #(.CNT_W(SUB_CNT_W)) u_sub_div (
    .clk(clk), .rst_n(rst_n_s), .en(sub_run && sub_tick),
    .clr(sub_change || stop_exit), .term(sub_term), .tick(sub_ce)
  );
endmodule

// File: rtl/clkpre_chk.sv
`timescale 1ns/1ps
module clkpre_chk
  import clkpre_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 6,
  parameter logic [ADDR_W-1:0] SUB_ADDR = 6'h29
) (
  input logic               clk,
  input logic               rst_n_s,
  input logic [1:0]         mode_q,
  input logic               commit,
  input logic               stop_exit,
  input logic               sys_ce,
  input logic               sub_ce,
  input logic [RATIO_W-1:0] sys_code,
  input logic               sub_sel,
  input logic               wr_en,
  input logic [ADDR_W-1:0]  wr_addr,
  input logic               err_flag
);
  p_commit_gated_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    commit |-> !sys_ce);

  p_gate_off_r4: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q != PM_ACTIVE) |-> !sys_ce);

  p_code_hold_r3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!commit && !stop_exit) |=> $stable(sys_code));

  p_sys_gap_r2: assert property (@(posedge clk) disable iff (!rst_n_s)
    sys_ce |=> !sys_ce);

  p_sub_lock_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mode_q != PM_ACTIVE) |=> $stable(sub_sel));

  p_err_set_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    (wr_en && (wr_addr == SUB_ADDR) && (mode_q != PM_ACTIVE)) |=> err_flag);

  p_sub_off_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    ((mode_q == PM_WATCH) || (mode_q == PM_STOP)) |-> !sub_ce);
endmodule

bind clkpre_top clkpre_chk #(.ADDR_W(ADDR_W), .SUB_ADDR(SUB_ADDR)) i_chk (
  .clk(clk), .rst_n_s(rst_n_s), .mode_q(mode_q), .commit(commit),
  .stop_exit(stop_exit), .sys_ce(sys_ce), .sub_ce(sub_ce),
  .sys_code(sys_code), .sub_sel(sub_sel), .wr_en(wr_en),
  .wr_addr(wr_addr), .err_flag(err_flag)
);

// File: tb/test_clkpre_top.sv
`timescale 1ns/1ps
module test_clkpre_top;
  localparam logic [5:0] A_SUB = 6'h29;
  localparam logic [5:0] A_SYS = 6'h2A;
  localparam logic [1:0] M_ACT = 2'b00, M_SUB = 2'b01, M_WAT = 2'b10, M_STP = 2'b11;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       strap_fast;
  logic [1:0] pwr_mode;
  logic       sub_tick;
  logic       wr_en;
  logic [5:0] wr_addr;
  logic [3:0] wr_data;
  logic [5:0] rd_addr;
  logic [3:0] rd_data;
  logic       sys_ce;
  logic       sub_ce;
  logic       tick_half;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  always @(negedge clk) sub_tick <= tick_half ? ~sub_tick : 1'b1;

  clkpre_top i_clkpre_top (
    .clk(clk), .rst_n(rst_n), .strap_fast(strap_fast), .pwr_mode(pwr_mode),
    .sub_tick(sub_tick), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sys_ce(sys_ce), .sub_ce(sub_ce)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [5:0] a, input logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic [5:0] a, output logic [3:0] d);
    rd_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    pwr_mode = m;
    @(negedge clk);
  endtask

  task automatic period(input bit use_sub, output int p);
    bit seen = 1'b0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      seen = use_sub ? sub_ce : sys_ce;
    end
    p = 0;
    if (!seen) begin p = -1; return; end
    seen = 1'b0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      p++;
      seen = use_sub ? sub_ce : sys_ce;
    end
    if (!seen) p = -1;
  endtask

  task automatic resume_first(output int n);
    bit seen = 1'b0;
    @(negedge clk);
    pwr_mode = M_ACT;
    n = 0;
    for (int i = 0; i < 200 && !seen; i++) begin
      @(negedge clk);
      n++;
      seen = sys_ce;
    end
    if (!seen) n = -1;
  endtask

  task automatic quiet_count(input int cycles, output int hits);
    hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (sys_ce) hits++;
    end
  endtask

  task automatic t_reset;
    logic [3:0] d;
    int p;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 sys_ce in reset", int'(sys_ce), 0);
    check("R7 sub_ce in reset", int'(sub_ce), 0);
    read_reg(A_SUB, d);
    check("R1 status in reset", int'(d), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    read_reg(A_SYS, d);
    check("R1 strap high code", int'(d[1:0]), 0);
    read_reg(A_SUB, d);
    check("R1 outstanding after reset", int'(d[0]), 0);
    period(1'b0, p);
    check("R2 period code 00", p, 4);
  endtask

  task automatic t_stage;
    logic [3:0] d;
    int p;
    write_reg(A_SYS, 4'b1001);
    read_reg(A_SYS, d);
    check("R3 staged code readback", int'(d[1:0]), 1);
    check("R6 immediate bits readback", int'(d[3:2]), 2);
    read_reg(A_SUB, d);
    check("R3 outstanding set", int'(d[0]), 1);
    period(1'b0, p);
    check("R3 running period unchanged", p, 4);
  endtask

  task automatic t_watch_resume;
    logic [3:0] d;
    int n, h;
    set_mode(M_WAT);
    quiet_count(40, h);
    check("R4 sys_ce gated in watch", h, 0);
    resume_first(n);
    check("R5 first pulse after watch resume", n, 8);
    read_reg(A_SUB, d);
    check("R5 outstanding cleared", int'(d[0]), 0);
    period(1'b0, n);
    check("R2 period code 01", n, 8);
  endtask

  task automatic t_subact_resume;
    int n, h;
    write_reg(A_SYS, 4'b0010);
    set_mode(M_SUB);
    quiet_count(30, h);
    check("R4 sys_ce gated in subactive", h, 0);
    resume_first(n);
    check("R4 R5 direct subactive commit", n, 16);
    write_reg(A_SYS, 4'b0011);
    set_mode(M_SUB);
    set_mode(M_WAT);
    resume_first(n);
    check("R5 first pulse code 11", n, 32);
    period(1'b0, n);
    check("R2 period code 11", n, 32);
  endtask

  task automatic t_sub_ratio;
    logic [3:0] d;
    int p;
    period(1'b1, p);
    check("R7 sub ratio 1/4", p, 4);
    write_reg(A_SUB, 4'b0100);
    read_reg(A_SUB, d);
    check("R7 sub bit readback", int'(d[2]), 1);
    period(1'b1, p);
    check("R7 sub ratio 1/8", p, 8);
    tick_half = 1'b1;
    period(1'b1, p);
    check("R7 sub ratio 1/8 slow tick", p, 16);
    tick_half = 1'b0;
    set_mode(M_SUB);
    period(1'b1, p);
    check("R7 sub runs in subactive", p, 8);
  endtask

  task automatic t_sub_locked;
    logic [3:0] d;
    int p;
    write_reg(A_SUB, 4'b0000);
    read_reg(A_SUB, d);
    check("R8 sub bit kept", int'(d[2]), 1);
    check("R8 error flag set", int'(d[3]), 1);
    period(1'b1, p);
    check("R8 sub period kept", p, 8);
    set_mode(M_ACT);
    write_reg(A_SUB, 4'b1100);
    read_reg(A_SUB, d);
    check("R8 error flag cleared", int'(d[3]), 0);
  endtask

  task automatic t_stop;
    logic [3:0] d;
    int p, h;
    write_reg(A_SYS, 4'b0001);
    set_mode(M_STP);
    quiet_count(20, h);
    check("R4 sys_ce gated in stop", h, 0);
    set_mode(M_ACT);
    read_reg(A_SYS, d);
    check("R9 staged code replaced", int'(d[1:0]), 0);
    read_reg(A_SUB, d);
    check("R9 outstanding cleared", int'(d[0]), 0);
    period(1'b0, p);
    check("R1 strap high after stop", p, 4);
    set_mode(M_STP);
    strap_fast = 1'b0;
    set_mode(M_ACT);
    read_reg(A_SYS, d);
    check("R1 strap low code", int'(d[1:0]), 3);
    period(1'b0, p);
    check("R1 strap low period", p, 32);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; strap_fast = 1'b1; pwr_mode = M_ACT; sub_tick = 1'b1;
    tick_half = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    t_reset();
    t_stage();
    t_watch_resume();
    t_subact_resume();
    t_sub_ratio();
    t_sub_locked();
    t_stop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule